// File: doc/BRIEF.md
# Ultrasonic Pulse-Echo Range Controller

This block runs one range measurement on a pulse-echo distance sensor each time it is asked to. A one-cycle start request launches a fixed-width trigger pulse toward the sensor. The block then waits for the sensor's echo line to go high and times how long it stays high. It converts that time into whole centimetres in hardware and finishes with a one-cycle done strobe. With the default 40 MHz clock the trigger lasts 10 us, one centimetre corresponds to 58 us of echo (2320 cycles), and any echo longer than 25 ms (1,000,000 cycles) is reported as no target.

The echo input is asynchronous and passes through a chain of flip-flops before the controller acts on its edges. The result is a distance value plus a no-target flag. Both are updated in the same cycle the done strobe is high and keep their values until the next measurement completes. The interface has no back-pressure: the result is a registered value qualified by the done strobe. A start request is only accepted when the controller is idle, so a caller can never overrun it.

Top module: `ultrasonic_ranger`

## Requirements
- R1: While reset is asserted and directly after it, trig_o and done_o are low, distance_o is 0 and no_target_o is 0.
- R2: A start_i sampled high in the idle state drives trig_o high from the next cycle for exactly TRIG_CYC consecutive cycles.
- R3: A start_i raised while a measurement is in progress is ignored: no second trigger pulse occurs and the running result is unaffected.
- R4: For an echo high for H clock cycles (H not above TIMEOUT_CYC), distance_o equals floor(H / CM_CYC).
- R5: An echo high for exactly TIMEOUT_CYC cycles is still measured. An echo high for more than TIMEOUT_CYC cycles gives no_target_o = 1 and distance_o = 0, with done_o raised once TIMEOUT_CYC cycles have passed since the echo rise was taken.
- R6: If no echo rising edge is seen within TIMEOUT_CYC cycles after the trigger pulse ends, the result is no_target_o = 1 and distance_o = 0.
- R7: done_o is high for exactly one cycle per measurement. For a measured echo it rises SYNC_STAGES+1 cycles after the echo input falls. distance_o and no_target_o change only in a cycle where done_o is high.
- R8: Echo edges that occur before the trigger pulse ends are not taken as the start of a measurement. An echo that is already high when the wait begins and stays high produces a no-target result (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (default 40 MHz timing) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one measurement; honoured only in idle |
| echo_i | input | 1 | Asynchronous echo line from the sensor |
| trig_o | output | 1 | Trigger pulse toward the sensor |
| distance_o | output | DIST_W | Measured distance in centimetres |
| no_target_o | output | 1 | High when the last result was a timeout |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The trigger pulse is due in the first cycle after the start request is sampled, so the bench samples trig_o on the falling clock edge that follows that rising edge. It then counts every high sample until the pulse drops. The done strobe of a measured echo is due SYNC_STAGES+1 rising edges after the bench lowers the echo, because the edge must cross the synchronizer and the detection flop and then the state register. A free-running rising-edge counter timestamps the lowering of the echo and the done strobe, and the bench compares the difference to that figure. Timeout results are awaited within a bounded window of TIMEOUT_CYC plus a margin, and the distance values and flags are captured only in the cycle that done_o is high.

// File: rtl/ur_pkg.sv
package ur_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRIGGER,
    ST_WAIT_ECHO,
    ST_MEASURE,
    ST_DONE
  } ur_state_e;
endpackage

// File: rtl/ur_echo_sync.sv
module ur_echo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic echo_async,
  output logic echo_lvl,
  output logic echo_rise,
  output logic echo_fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= echo_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];

  assign echo_lvl  = chain_q[STAGES-1];
  assign echo_rise = chain_q[STAGES-1] & ~last_q;
  assign echo_fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/ur_cm_convert.sv
module ur_cm_convert #(
  parameter int CM_CYC = 2320,
  parameter int DIST_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  output logic [DIST_W-1:0] cm_total
);
  localparam int PRE_W = $clog2(CM_CYC + 1);

  logic [PRE_W-1:0]  pre_q;
  logic [DIST_W-1:0] cm_q;
  logic              tick;

  assign tick     = (pre_q == PRE_W'(CM_CYC - 1));
  assign cm_total = cm_q + DIST_W'(tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cm_q  <= '0;
    end else if (clr) begin
      pre_q <= '0;
      cm_q  <= '0;
    end else if (en) begin
      if (tick) begin
        pre_q <= '0;
        cm_q  <= cm_total;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ur_seq_fsm.sv
module ur_seq_fsm
  import ur_pkg::*;
#(
  parameter int TRIG_CYC    = 400,
  parameter int TIMEOUT_CYC = 1000000,
  parameter int DIST_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              echo_rise,
  input  logic              echo_fall,
  input  logic [DIST_W-1:0] cm_total,
  output logic              conv_clr,
  output logic              conv_en,
  output logic              trig,
  output logic              done,
  output logic [DIST_W-1:0] dist_q,
  output logic              no_tgt_q
);
  localparam int WIN_MAX = (TIMEOUT_CYC > TRIG_CYC) ? TIMEOUT_CYC : TRIG_CYC;
  localparam int CNT_W   = $clog2(WIN_MAX + 1);

  ur_state_e        state_q, state_d;
  logic [CNT_W-1:0] win_q;
  logic             win_trig_end, win_timeout;
  logic             load_res, load_nt;

  assign win_trig_end = (win_q == CNT_W'(TRIG_CYC - 1));
  assign win_timeout  = (win_q == CNT_W'(TIMEOUT_CYC - 1));

  always_comb begin
    state_d  = state_q;
    load_res = 1'b0;
    load_nt  = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (start_req) state_d = ST_TRIGGER;
      ST_TRIGGER:   if (win_trig_end) state_d = ST_WAIT_ECHO;
      ST_WAIT_ECHO: begin
        if (echo_rise) begin
          state_d = ST_MEASURE;
        end else if (win_timeout) begin
          state_d  = ST_DONE;
          load_res = 1'b1;
          load_nt  = 1'b1;
        end
      end
      ST_MEASURE: begin
        if (echo_fall) begin
          state_d  = ST_DONE;
          load_res = 1'b1;
        end else if (win_timeout) begin
          state_d  = ST_DONE;
          load_res = 1'b1;
          load_nt  = 1'b1;
        end
      end
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)
        win_q <= '0;
      else if (state_q == ST_TRIGGER || state_q == ST_WAIT_ECHO || state_q == ST_MEASURE)
        win_q <= win_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_q   <= '0;
      no_tgt_q <= 1'b0;
    end else if (load_res) begin
      dist_q   <= load_nt ? '0 : cm_total;
      no_tgt_q <= load_nt;
    end
  end

  assign conv_clr = (state_q == ST_WAIT_ECHO) && echo_rise;
  assign conv_en  = (state_q == ST_MEASURE);
  assign trig     = (state_q == ST_TRIGGER);
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/ultrasonic_ranger.sv
module ultrasonic_ranger #(
  parameter int TRIG_CYC    = 400,
  parameter int CM_CYC      = 2320,
  parameter int TIMEOUT_CYC = 1000000,
  parameter int SYNC_STAGES = 2,
  localparam int DIST_W     = $clog2(TIMEOUT_CYC / CM_CYC + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              echo_i,
  output logic              trig_o,
  output logic [DIST_W-1:0] distance_o,
  output logic              no_target_o,
  output logic              done_o
);
  logic              echo_lvl, echo_rise, echo_fall;
  logic              conv_clr, conv_en;
  logic [DIST_W-1:0] cm_total;

  ur_echo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .echo_async (echo_i),
    .echo_lvl   (echo_lvl),
    .echo_rise  (echo_rise),
    .echo_fall  (echo_fall)
  );

  ur_cm_convert #(.CM_CYC(CM_CYC), .DIST_W(DIST_W)) u_conv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (conv_clr),
    .en       (conv_en),
    .cm_total (cm_total)
  );

  ur_seq_fsm #(
    .TRIG_CYC    (TRIG_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .DIST_W      (DIST_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_i),
    .echo_rise (echo_rise),
    .echo_fall (echo_fall),
    .cm_total  (cm_total),
    .conv_clr  (conv_clr),
    .conv_en   (conv_en),
    .trig      (trig_o),
    .done      (done_o),
    .dist_q    (distance_o),
    .no_tgt_q  (no_target_o)
  );

  logic unused_lvl;
  assign unused_lvl = echo_lvl;
endmodule

// File: rtl/ur_checker.sv
module ur_checker #(
  parameter int TRIG_CYC = 400,
  parameter int DIST_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              trig_o,
  input logic              done_o,
  input logic              no_target_o,
  input logic [DIST_W-1:0] distance_o
);
  localparam int HW = $clog2(TRIG_CYC + 2);
  logic [HW-1:0] high_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      high_run <= '0;
    else if (trig_o) high_run <= high_run + 1'b1;
    else             high_run <= '0;

  p_trig_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(start_i));

  p_trig_not_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (high_run < HW'(TRIG_CYC)));

  p_trig_full_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_o) |-> (high_run == HW'(TRIG_CYC)));

  p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(distance_o) && $stable(no_target_o)));

  p_no_target_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && no_target_o) |-> (distance_o == '0));

  p_done_not_in_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !trig_o);
endmodule

bind ultrasonic_ranger ur_checker #(.TRIG_CYC(TRIG_CYC), .DIST_W(DIST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .trig_o      (trig_o),
  .done_o      (done_o),
  .no_target_o (no_target_o),
  .distance_o  (distance_o)
);

// File: tb/tb_ultrasonic_ranger.sv
module tb_ultrasonic_ranger;
  localparam int TRIG = 8;
  localparam int CM   = 20;
  localparam int TO   = 600;
  localparam int SYNC = 2;
  localparam int DW   = $clog2(TO / CM + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          echo_i = 1'b0;
  logic          trig_o, no_target_o, done_o;
  logic [DW-1:0] distance_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  int done_cyc = 0;
  int trig_rises = 0;
  logic trig_prev = 1'b0;
  logic [DW-1:0] cap_dist;
  logic          cap_nt;
  bit finished = 0;

  ultrasonic_ranger #(
    .TRIG_CYC(TRIG), .CM_CYC(CM), .TIMEOUT_CYC(TO), .SYNC_STAGES(SYNC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .echo_i(echo_i),
    .trig_o(trig_o), .distance_o(distance_o),
    .no_target_o(no_target_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (done_o) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
      cap_dist = distance_o;
      cap_nt   = no_target_o;
    end
    if (trig_o && !trig_prev) trig_rises = trig_rises + 1;
    trig_prev = trig_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire_trigger(input string tag);
    int width;
    int rises0;
    rises0 = trig_rises;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(trig_o == 1'b1, {"R2 trig high one cycle after start ", tag}, trig_o, 1);
    width = 0;
    while (trig_o && width < TRIG + 5) begin
      width++;
      @(negedge clk);
    end
    chk(width == TRIG, {"R2 trig width ", tag}, width, TRIG);
    chk(trig_rises == rises0 + 1, {"R2 one trig pulse ", tag}, trig_rises, rises0 + 1);
  endtask

  task automatic wait_done(input int prev, input int limit);
    for (int k = 0; k < limit && done_cnt == prev; k++) @(negedge clk);
  endtask

  // measured-echo scenario: echo high for h cycles after gap cycles of waiting
  task automatic run_echo(input int h, input int gap, input bit busy_start,
                          input int exp_dist, input bit exp_nt, input string tag);
    int prev;
    int fall_cyc;
    int rises_after;
    fire_trigger(tag);
    rises_after = trig_rises;
    prev = done_cnt;
    repeat (gap) @(negedge clk);
    echo_i = 1'b1;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      start_i = (busy_start && i == h / 2);
    end
    start_i  = 1'b0;
    echo_i   = 1'b0;
    fall_cyc = cyc;
    wait_done(prev, 60);
    chk(done_cnt == prev + 1, {"R7 single done ", tag}, done_cnt - prev, 1);
    chk(cap_nt == exp_nt, {"R5 no_target flag ", tag}, cap_nt, exp_nt);
    chk(cap_dist == DW'(exp_dist), {"R4 distance ", tag}, cap_dist, exp_dist);
    if (!exp_nt)
      chk(done_cyc - fall_cyc == SYNC + 1, {"R7 done latency ", tag}, done_cyc - fall_cyc, SYNC + 1);
    repeat (10) @(negedge clk);
    chk(trig_rises == rises_after, {"R3 no extra trigger ", tag}, trig_rises, rises_after);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(trig_o == 1'b0, "R1 trig in reset", trig_o, 0);
    chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
    chk(distance_o == '0, "R1 distance in reset", distance_o, 0);
    chk(no_target_o == 1'b0, "R1 no_target in reset", no_target_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(trig_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", {trig_o, done_o}, 0);
  endtask

  task automatic test_distances();
    run_echo(19, 3, 0, 0, 0, "h19");
    run_echo(59, 5, 0, 2, 0, "h59");
    run_echo(60, 2, 0, 3, 0, "h60");
    run_echo(247, 10, 0, 12, 0, "h247");
  endtask

  task automatic test_echo_timeout();
    run_echo(TO, 4, 0, TO / CM, 0, "R5 h=TO measured");
    run_echo(TO + 1, 4, 0, 0, 1, "R5 h=TO+1 no target");
    run_echo(TO + 40, 4, 0, 0, 1, "R5 long echo");
  endtask

  task automatic test_no_echo();
    int prev;
    fire_trigger("R6");
    prev = done_cnt;
    wait_done(prev, TO + 50);
    chk(done_cnt == prev + 1, "R6 done after wait timeout", done_cnt - prev, 1);
    chk(cap_nt == 1'b1, "R6 no_target set", cap_nt, 1);
    chk(cap_dist == '0, "R6 distance zero", cap_dist, 0);
  endtask

  task automatic test_busy_start();
    run_echo(100, 3, 1, 5, 0, "R3 start during measure");
  endtask

  task automatic test_early_echo();
    int prev;
    prev = done_cnt;
    echo_i = 1'b1;
    fire_trigger("R8");
    wait_done(prev, TO + 50);
    echo_i = 1'b0;
    chk(done_cnt == prev + 1, "R8 done with echo high from start", done_cnt - prev, 1);
    chk(cap_nt == 1'b1, "R8 early echo not measured", cap_nt, 1);
    repeat (10) @(negedge clk);
  endtask

  task automatic test_hold();
    logic [DW-1:0] d0;
    logic          n0;
    run_echo(85, 3, 0, 4, 0, "R7 hold setup");
    d0 = distance_o;
    n0 = no_target_o;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (TRIG + 20) @(negedge clk);
    chk(distance_o == d0, "R7 distance held into next run", distance_o, d0);
    chk(no_target_o == n0, "R7 flag held into next run", no_target_o, n0);
    echo_i = 1'b1;
    repeat (41) @(negedge clk);
    echo_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(distance_o == DW'(2), "R7 new result after done", distance_o, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_distances();
    test_echo_timeout();
    test_no_echo();
    test_busy_start();
    test_early_echo();
    test_hold();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule